// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is a trace sink that records a stream of 32-bit trace words into an on-chip RAM treated as a ring. A trace source presents words with a valid strobe and may mark an event with a trigger strobe. Software reaches the block through a simple register bus with separate read and write strobes and a word address. Through that bus it can also fill and drain the RAM. Writing the write-data register stores a word at the write pointer and steps that pointer. Reading the read-data register returns the word at the read pointer and steps that pointer. Both pointers wrap at the RAM depth.

Capture runs while the enable bit is set. Capture can end in three ways: software clears the enable bit, a programmed number of words arrive after a trigger, or a manual flush completes with the stop-on-flush bit set. Whenever the block finishes on its own, it first pads the current 4-word frame with zero words. The write pointer therefore always rests on a frame boundary. A sticky flag records that the write pointer has wrapped and that old data has been overwritten.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset, both pointers, the status register, the control register, the trigger count and the flush control register read 0. The depth register (0x004) reads the DEPTH parameter. The flush status register (0x300) reads 0x2.
- R2: A bus write to 0x024 stores the written word at the write pointer. The write pointer then advances by one, modulo DEPTH.
- R3: A bus read of 0x010 returns the RAM word at the read pointer in the same cycle. The read pointer then advances by one, modulo DEPTH.
- R4: A bus write to 0x014 (read pointer) or 0x018 (write pointer) loads that pointer, and reading the same address returns the loaded value. Writing the write pointer clears the full flag.
- R5: Status bit 0 (0x00C) is set when the write pointer steps from DEPTH-1 to 0. It stays set until the write pointer is written.
- R6: With control bit 0 (0x020) set, each cycle with trace valid stores the trace word and advances the write pointer. With the bit clear, trace words are ignored and the write pointer does not move.
- R7: When flush control bit 13 (0x304) is set, the first trigger strobe during capture arms the stop. After the trigger cycle, capture accepts exactly the number of further words held in the trigger count register (0x01C). The block then pads with zero words up to a multiple of 4, stops capturing, and flush status bit 1 reads 1.
- R8: With flush control bit 13 clear, the trigger strobe has no effect on capture.
- R9: Writing 1 to flush control bit 6 starts a manual flush. The bit reads 1 while the block writes zero words up to the next multiple of 4, and then clears itself. Trace words presented during that padding are dropped.
- R10: If flush control bit 12 is set, flush completion stops capture and flush status bit 1 reads 1. If bit 12 is clear, capture resumes after the flush.
- R11: Any write to the control register clears a trigger or flush stop. Flush status bit 1 reads 1 exactly when control bit 0 is clear or capture is stopped.
- R12: If a bus write to 0x024 or 0x018 occurs in the same cycle as a trace word, the bus access wins. The trace word is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read-data access advances the read pointer) |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data, valid in the cycle of bus_rd |
| trc_valid | input | 1 | Trace word valid |
| trc_data | input | DATA_W | Trace word |
| trc_trigger | input | 1 | Trigger event strobe |

## Verification
The hardest case to reach is the exact end of a trigger-counted stop. Frame padding must take over in the cycle after the last counted word, while trace words are still arriving back to back. The bench keeps the valid strobe high continuously through the trigger and beyond. It sweeps the post-trigger count from 0 to 5, so every frame offset of the stop point occurs. Each final pointer is compared with the rounded-up word count, and the RAM is read back to confirm the boundary between captured words and zero padding. The flush sweep covers every frame offset in the same way and injects trace words during the padding.

// File: rtl/trs_pkg.sv
package trs_pkg;
   localparam logic [11:0] OFS_DEPTH = 12'h004;
   localparam logic [11:0] OFS_STAT  = 12'h00C;
   localparam logic [11:0] OFS_RDAT  = 12'h010;
   localparam logic [11:0] OFS_RPTR  = 12'h014;
   localparam logic [11:0] OFS_WPTR  = 12'h018;
   localparam logic [11:0] OFS_TCNT  = 12'h01C;
   localparam logic [11:0] OFS_CTRL  = 12'h020;
   localparam logic [11:0] OFS_WDAT  = 12'h024;
   localparam logic [11:0] OFS_FSTAT = 12'h300;
   localparam logic [11:0] OFS_FCTL  = 12'h304;

   localparam int FC_FMT     = 0;
   localparam int FC_FLUSH   = 6;
   localparam int FC_STOPFL  = 12;
   localparam int FC_STOPTRG = 13;

   typedef struct packed {
      logic stop_trg;
      logic stop_flush;
      logic fmt_en;
   } fctl_t;
endpackage

// File: rtl/trs_ptr.sv
module trs_ptr #(
   parameter int DEPTH = 64,
   localparam int PW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [PW-1:0] load_val,
   input  logic          inc,
   output logic [PW-1:0] ptr,
   output logic          wrap
);
   logic [PW-1:0] nxt;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign nxt = ptr + 1'b1;
      end else begin : g_cmp
         assign nxt = (ptr == PW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
      end
   endgenerate

   assign wrap = inc && !load && (ptr == PW'(DEPTH - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (load) ptr <= load_val;
      else if (inc)  ptr <= nxt;
   end

   // R2 / R3: one step per access, away from the end of the RAM
   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load && ptr != PW'(DEPTH - 1)) |=> ptr == $past(ptr) + 1'b1);
   // R5: stepping past the end lands on zero
   a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> ptr == '0);
   // R4: direct load
   a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> ptr == $past(load_val));
endmodule

// File: rtl/trs_ram.sv
module trs_ram #(
   parameter int DEPTH = 64,
   parameter int DATA_W = 32,
   localparam int PW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [PW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [PW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/trs_ctrl.sv
module trs_ctrl #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_en,
   input  logic          trc_valid,
   input  logic          trc_trigger,
   input  logic          stop_on_trig,
   input  logic          stop_on_flush,
   input  logic          flush_req,
   input  logic          ctrl_wr,
   input  logic [TW-1:0] tcnt,
   input  logic          aligned,
   input  logic          slot_free,
   output logic          cap_we,
   output logic          pad_we,
   output logic          flush_busy,
   output logic          halted
);
   logic          armed;
   logic          stop_pend;
   logic [TW-1:0] remain;
   logic          finishing;
   logic          done;
   logic          trig_hit;

   assign finishing = flush_busy || stop_pend;
   assign cap_we    = cap_en && trc_valid && !halted && !finishing && slot_free;
   assign pad_we    = finishing && !aligned && slot_free;
   assign done      = finishing && aligned;
   assign trig_hit  = cap_en && !halted && !finishing && trc_trigger &&
                      stop_on_trig && !armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted    <= 1'b0;
         armed     <= 1'b0;
         stop_pend <= 1'b0;
         remain    <= '0;
      end else if (ctrl_wr) begin
         halted    <= 1'b0;
         armed     <= 1'b0;
         stop_pend <= 1'b0;
      end else begin
         if (trig_hit) begin
            armed  <= 1'b1;
            remain <= tcnt;
            if (tcnt == '0) stop_pend <= 1'b1;
         end else if (armed && cap_we) begin
            remain <= remain - 1'b1;
            if (remain == TW'(1)) stop_pend <= 1'b1;
         end
         if (done) begin
            stop_pend <= 1'b0;
            if (stop_pend || (flush_busy && stop_on_flush)) halted <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flush_busy <= 1'b0;
      else if (flush_req) flush_busy <= 1'b1;
      else if (done)      flush_busy <= 1'b0;
   end

   // R9: a flush on a frame boundary clears its busy bit on the next edge
   a_r9_flush_done: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_busy && aligned && !flush_req) |=> !flush_busy);
   // R10: stop-on-flush halts capture once the flush completes
   a_r10_flush_halt: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_busy && aligned && stop_on_flush && !flush_req && !ctrl_wr) |=> halted);
   // R11: a control write always clears a stop
   a_r11_ctrl_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> !halted);
   // R7: a stop holds until software intervenes
   a_r7_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !ctrl_wr) |=> halted);
   // R7: zero post-trigger count requests the stop at once
   a_r7_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_hit && tcnt == '0 && !ctrl_wr) |=> stop_pend);
endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink
   import trs_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int FRAME  = 4,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 12,
   parameter int TCNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              trc_valid,
   input  logic [DATA_W-1:0] trc_data,
   input  logic              trc_trigger
);
   localparam int PW = $clog2(DEPTH);
   localparam int FB = $clog2(FRAME);

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("trace_ring_sink: DATA_W must be 32");
      end
      if (FRAME < 2 || (FRAME & (FRAME - 1)) != 0) begin : g_bad_frame
         $error("trace_ring_sink: FRAME must be a power of two >= 2");
      end
      if (DEPTH % FRAME != 0) begin : g_bad_depth
         $error("trace_ring_sink: DEPTH must be a multiple of FRAME");
      end
      if (TCNT_W > DATA_W || TCNT_W < 1) begin : g_bad_tcnt
         $error("trace_ring_sink: TCNT_W out of range");
      end
      if (ADDR_W < 12) begin : g_bad_addr
         $error("trace_ring_sink: ADDR_W must be at least 12");
      end
   endgenerate

   // register decode
   logic wr_wdat, wr_wptr, wr_rptr, wr_ctrl, wr_tcnt, wr_fctl, rd_rdat;
   assign wr_wdat = bus_wr && (bus_addr == ADDR_W'(OFS_WDAT));
   assign wr_wptr = bus_wr && (bus_addr == ADDR_W'(OFS_WPTR));
   assign wr_rptr = bus_wr && (bus_addr == ADDR_W'(OFS_RPTR));
   assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
   assign wr_tcnt = bus_wr && (bus_addr == ADDR_W'(OFS_TCNT));
   assign wr_fctl = bus_wr && (bus_addr == ADDR_W'(OFS_FCTL));
   assign rd_rdat = bus_rd && (bus_addr == ADDR_W'(OFS_RDAT));

   // software state
   logic              cap_en;
   fctl_t             fctl;
   logic [TCNT_W-1:0] tcnt;
   logic              full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_en <= 1'b0;
         fctl   <= '0;
         tcnt   <= '0;
      end else begin
         if (wr_ctrl) cap_en <= bus_wdata[0];
         if (wr_tcnt) tcnt   <= bus_wdata[TCNT_W-1:0];
         if (wr_fctl) begin
            fctl.stop_trg   <= bus_wdata[FC_STOPTRG];
            fctl.stop_flush <= bus_wdata[FC_STOPFL];
            fctl.fmt_en     <= bus_wdata[FC_FMT];
         end
      end
   end

   // capture engine
   logic [PW-1:0] wptr, rptr;
   logic          wwrap, rwrap;
   logic          cap_we, pad_we, flush_busy, halted;
   logic          slot_free, aligned, ram_we;
   logic [DATA_W-1:0] ram_wdata, ram_rdata;

   assign slot_free = !wr_wdat && !wr_wptr;
   assign aligned   = (wptr[FB-1:0] == '0);
   assign ram_we    = wr_wdat || cap_we || pad_we;
   assign ram_wdata = wr_wdat ? bus_wdata : (pad_we ? '0 : trc_data);

   trs_ctrl #(.TW(TCNT_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .cap_en        (cap_en),
      .trc_valid     (trc_valid),
      .trc_trigger   (trc_trigger),
      .stop_on_trig  (fctl.stop_trg),
      .stop_on_flush (fctl.stop_flush),
      .flush_req     (wr_fctl && bus_wdata[FC_FLUSH]),
      .ctrl_wr       (wr_ctrl),
      .tcnt          (tcnt),
      .aligned       (aligned),
      .slot_free     (slot_free),
      .cap_we        (cap_we),
      .pad_we        (pad_we),
      .flush_busy    (flush_busy),
      .halted        (halted)
   );

   trs_ptr #(.DEPTH(DEPTH)) u_wptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_wptr),
      .load_val (bus_wdata[PW-1:0]),
      .inc      (ram_we),
      .ptr      (wptr),
      .wrap     (wwrap)
   );

   trs_ptr #(.DEPTH(DEPTH)) u_rptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_rptr),
      .load_val (bus_wdata[PW-1:0]),
      .inc      (rd_rdat),
      .ptr      (rptr),
      .wrap     (rwrap)
   );

   trs_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .waddr (wptr),
      .wdata (ram_wdata),
      .raddr (rptr),
      .rdata (ram_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       full <= 1'b0;
      else if (wr_wptr) full <= 1'b0;
      else if (wwrap)   full <= 1'b1;
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (bus_addr)
            ADDR_W'(OFS_DEPTH): bus_rdata = DATA_W'(DEPTH);
            ADDR_W'(OFS_STAT):  bus_rdata = DATA_W'(full);
            ADDR_W'(OFS_RDAT):  bus_rdata = ram_rdata;
            ADDR_W'(OFS_RPTR):  bus_rdata = DATA_W'(rptr);
            ADDR_W'(OFS_WPTR):  bus_rdata = DATA_W'(wptr);
            ADDR_W'(OFS_TCNT):  bus_rdata = DATA_W'(tcnt);
            ADDR_W'(OFS_CTRL):  bus_rdata = DATA_W'(cap_en);
            ADDR_W'(OFS_FSTAT): bus_rdata = DATA_W'({!cap_en || halted, 1'b0});
            ADDR_W'(OFS_FCTL): begin
               bus_rdata[FC_STOPTRG] = fctl.stop_trg;
               bus_rdata[FC_STOPFL]  = fctl.stop_flush;
               bus_rdata[FC_FLUSH]   = flush_busy;
               bus_rdata[FC_FMT]     = fctl.fmt_en;
            end
            default: bus_rdata = '0;
         endcase
      end
   end

   logic unused_sink;
   assign unused_sink = &{1'b0, bus_wdata, rwrap};

   // R5: the full flag is sticky until the write pointer is loaded
   a_r5_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !wr_wptr) |=> full);
   // R4: loading the write pointer clears the full flag
   a_r4_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
      wr_wptr |=> !full);
   // R6: with no RAM write and no load, the write pointer stays put
   a_r6_wptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ram_we && !wr_wptr) |=> $stable(wptr));
   // R12: a bus write to the RAM never coincides with an accepted trace word
   a_r12_bus_first: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_wdat && trc_valid) |=> wptr == $past(wptr) + 1'b1 || $past(wptr) == PW'(DEPTH - 1));
endmodule

// File: tb/tb_trace_ring_sink.sv
module tb_trace_ring_sink;
   localparam int DEPTH = 16;
   localparam int FRAME = 4;

   localparam logic [11:0] A_DEPTH = 12'h004, A_STAT = 12'h00C, A_RDAT = 12'h010,
                           A_RPTR = 12'h014, A_WPTR = 12'h018, A_TCNT = 12'h01C,
                           A_CTRL = 12'h020, A_WDAT = 12'h024, A_FSTAT = 12'h300,
                           A_FCTL = 12'h304;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        trc_valid = 1'b0;
   logic [31:0] trc_data = '0;
   logic        trc_trigger = 1'b0;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   trace_ring_sink #(.DEPTH(DEPTH), .FRAME(FRAME), .DATA_W(32), .ADDR_W(12), .TCNT_W(16)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trc_valid(trc_valid),
      .trc_data(trc_data), .trc_trigger(trc_trigger)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic bwr(input logic [11:0] a, input logic [31:0] d);
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic brd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic push(input logic [31:0] d, input logic trg);
      trc_valid = 1'b1; trc_data = d; trc_trigger = trg;
      @(negedge clk);
      trc_valid = 1'b0; trc_trigger = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset values
      brd(A_DEPTH, v); chk("R1 depth", v, DEPTH);
      brd(A_STAT, v);  chk("R1 status", v, 0);
      brd(A_WPTR, v);  chk("R1 wptr", v, 0);
      brd(A_RPTR, v);  chk("R1 rptr", v, 0);
      brd(A_CTRL, v);  chk("R1 ctrl", v, 0);
      brd(A_TCNT, v);  chk("R1 tcnt", v, 0);
      brd(A_FCTL, v);  chk("R1 fctl", v, 0);
      brd(A_FSTAT, v); chk("R1 fstat", v, 32'h2);

      // R2 R4 R5: every pointer start, one data write each
      for (int p = 0; p < DEPTH; p++) begin
         bwr(A_WPTR, p);
         brd(A_STAT, v); chk("R4 full cleared by pointer load", v, 0);
         bwr(A_WDAT, 32'h5A00 + p);
         brd(A_WPTR, v); chk("R2 wptr step", v, (p + 1) % DEPTH);
         brd(A_STAT, v); chk("R5 full on wrap", v, (p == DEPTH - 1) ? 1 : 0);
      end
      bwr(A_WDAT, 32'h5A00);
      brd(A_STAT, v); chk("R5 full sticky", v, 1);

      // R3: drain the whole ring through the read-data register
      bwr(A_RPTR, 0);
      for (int i = 0; i < DEPTH; i++) begin
         brd(A_RDAT, v); chk("R3 read data", v, 32'h5A00 + i);
      end
      brd(A_RPTR, v); chk("R3 rptr wrapped", v, 0);
      bwr(A_RPTR, 9);
      brd(A_RPTR, v); chk("R4 rptr load", v, 9);
      bwr(A_WPTR, 5);
      brd(A_WPTR, v); chk("R4 wptr load", v, 5);

      // R6: capture disabled ignores trace
      bwr(A_WPTR, 0);
      push(32'hDEAD0001, 1'b0); push(32'hDEAD0002, 1'b0); push(32'hDEAD0003, 1'b0);
      brd(A_WPTR, v); chk("R6 disabled no move", v, 0);

      // R6 R8: capture on, trigger without stop-on-trigger
      bwr(A_FCTL, 32'h1);
      bwr(A_CTRL, 1);
      for (int i = 0; i < 6; i++) push(32'hC000 + i, (i == 2));
      brd(A_WPTR, v);  chk("R6 capture count", v, 6);
      brd(A_FSTAT, v); chk("R8 trigger ignored", v, 0);
      bwr(A_RPTR, 0);
      for (int i = 0; i < 6; i++) begin
         brd(A_RDAT, v); chk("R6 captured word", v, 32'hC000 + i);
      end

      // R7: trigger-counted stop, post count 0..5
      for (int n = 0; n < 6; n++) begin
         int stored;
         int fin;
         stored = 3 + n;
         fin = ((stored + FRAME - 1) / FRAME) * FRAME;
         bwr(A_CTRL, 0);
         bwr(A_WPTR, 0);
         bwr(A_TCNT, n);
         bwr(A_FCTL, 32'h2001);
         bwr(A_CTRL, 1);
         for (int i = 0; i < n + 6; i++) push(32'hA0000000 + (n << 8) + i, (i == 2));
         idle(6);
         brd(A_WPTR, v);  chk("R7 stop pointer", v, fin % DEPTH);
         brd(A_FSTAT, v); chk("R7 stopped status", v, 32'h2);
         bwr(A_RPTR, 0);
         for (int i = 0; i < fin; i++) begin
            brd(A_RDAT, v);
            chk("R7 captured or padded", v, (i < stored) ? 32'hA0000000 + (n << 8) + i : 0);
         end
      end

      // R9 R10: manual flush at every frame offset, capture resumes
      for (int k = 1; k <= FRAME; k++) begin
         int fin;
         fin = ((k + FRAME - 1) / FRAME) * FRAME;
         bwr(A_CTRL, 0);
         bwr(A_WPTR, 0);
         bwr(A_FCTL, 32'h1);
         bwr(A_CTRL, 1);
         for (int i = 0; i < k; i++) push(32'hF100 + i, 1'b0);
         bwr(A_FCTL, 32'h41);
         brd(A_FCTL, v); chk("R9 flush busy", v, 32'h41);
         if (k == 1) begin
            push(32'hBAD0, 1'b0); push(32'hBAD1, 1'b0);
         end
         idle(6);
         brd(A_FCTL, v);  chk("R9 flush self-clears", v, 32'h1);
         brd(A_WPTR, v);  chk("R9 frame padded", v, fin);
         brd(A_FSTAT, v); chk("R10 no stop without bit 12", v, 0);
         bwr(A_RPTR, k);
         for (int i = k; i < fin; i++) begin
            brd(A_RDAT, v); chk("R9 pad word zero", v, 0);
         end
         push(32'hF1FF, 1'b0);
         brd(A_WPTR, v); chk("R10 capture resumes", v, fin + 1);
      end

      // R10 R11: flush with stop, then restart by control write
      bwr(A_CTRL, 0);
      bwr(A_WPTR, 0);
      bwr(A_FCTL, 32'h1001);
      bwr(A_CTRL, 1);
      push(32'hE0, 1'b0); push(32'hE1, 1'b0);
      bwr(A_FCTL, 32'h1041);
      idle(6);
      brd(A_WPTR, v);  chk("R10 padded before stop", v, 4);
      brd(A_FSTAT, v); chk("R10 stopped after flush", v, 32'h2);
      push(32'hE2, 1'b0); push(32'hE3, 1'b0);
      brd(A_WPTR, v);  chk("R10 no capture when stopped", v, 4);
      bwr(A_CTRL, 1);
      brd(A_FSTAT, v); chk("R11 control write clears stop", v, 0);
      push(32'hE4, 1'b0);
      brd(A_WPTR, v);  chk("R11 capture after restart", v, 5);
      bwr(A_CTRL, 0);
      brd(A_FSTAT, v); chk("R11 disabled reads stopped", v, 32'h2);

      // R12: bus write and trace word in one cycle
      bwr(A_FCTL, 32'h1);
      bwr(A_WPTR, 0);
      bwr(A_CTRL, 1);
      bus_addr = A_WDAT; bus_wr = 1'b1; bus_wdata = 32'h0B0B0B0B;
      trc_valid = 1'b1; trc_data = 32'h0A0A0A0A;
      @(negedge clk);
      bus_wr = 1'b0; trc_valid = 1'b0;
      brd(A_WPTR, v); chk("R12 single advance", v, 1);
      bwr(A_RPTR, 0);
      brd(A_RDAT, v); chk("R12 bus word wins", v, 32'h0B0B0B0B);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule